// File: doc/BRIEF.md
# Synchronous Burst Static RAM

This block is a clocked static RAM with bursts. Each word holds four byte lanes, and each lane can be written on its own. Every control input, the address and the write data are sampled on the rising clock edge into one input stage. The access then takes place on the following edge. Read data is therefore registered and appears after the second edge.

A burst is opened by one of two address strobes:

- The controller strobe starts a read or a write burst when chip enable is asserted. The same strobe with chip enable deasserted ends any burst.
- The processor strobe starts a burst only when chip enable is asserted. Its first beat is always a read.

After the first beat, each cycle with burst advance asserted steps a 2-bit counter. The next address stays inside the same aligned group of four words. A mode input chooses the order of the low address bits: linear (start plus count) or interleaved (start XOR count). With advance deasserted, the same word is accessed again.

Output enable gates the read bus without delay. A sleep input blocks every access and freezes the burst position.

Top module: `burst_sram`

## Requirements
- R1: After reset, dataOut is all zeros, and no burst is open: advance-only cycles give no read data (dataOut stays zero).
- R2: Inputs are sampled on the rising edge, and the access happens on the next rising edge. Read data for a strobe sampled on edge N is valid on dataOut after edge N+1 and until edge N+2.
- R3: A controller strobe with chip enable asserted loads the address and starts a burst. A controller strobe with chip enable deasserted closes the burst: that cycle and later advance cycles give zero read data.
- R4: A processor strobe with chip enable deasserted is ignored. When both strobes are asserted together, the controller strobe wins: its write request is honoured.
- R5: The first beat of a burst opened by the processor strobe is a read, even when lane or global write enables are active.
- R6: In linear mode (interleave=0), the low two address bits of beat k are (start+k) mod 4, and the upper address bits never change inside a burst.
- R7: In interleaved mode (interleave=1), the low two address bits of beat k are start XOR k.
- R8: A continuation cycle with advance deasserted accesses the same word again, so the burst stalls.
- R9: Lane i covers data bits [9i+8:9i]. A write beat updates only the lanes whose active-low lane enable laneWrN[i] is 0. The other lanes keep their contents.
- R10: An active-low global write (allWrN=0) writes all four lanes, whatever the lane enables are.
- R11: While outEnN is 1, dataOut is zero at once, with no clock edge needed. Setting outEnN back to 0 shows the registered read data again.
- R12: A cycle sampled with sleep=1 writes nothing and leaves the burst position unchanged. Its read data is zero.
- R13: A cycle that does not perform a read gives zero read data: writes, idle cycles and deselect cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data, lane i at bits [9i+8:9i] |
| chipEnN | input | 1 | Active-low chip enable |
| procStrobeN | input | 1 | Active-low processor address strobe |
| ctrlStrobeN | input | 1 | Active-low controller address strobe |
| advanceN | input | 1 | Active-low burst advance |
| laneWrN | input | LANES | Active-low per-lane write enables |
| allWrN | input | 1 | Active-low global write |
| sleep | input | 1 | Blocks access and holds burst state when high |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| outEnN | input | 1 | Active-low asynchronous output enable |
| dataOut | output | LANES*LANE_W | Read data, zero when not enabled or not reading |

## Verification
The bench builds the block with its default parameters: a 6-bit address (64 words, sixteen burst groups), four 9-bit lanes and a 2-bit burst counter.

- With only 64 words, the bench can fill the whole memory first. Random addresses then revisit words often, so partial writes pile up on data that is already known.
- With four offsets per group, the bench can walk every start offset in both orders, including the wrap at the group edge.
- Random stimulus mixes strobes, sleep, stalls and mode changes between beats. This exposes the interactions between the strobes that directed cases seldom reach.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Access strobes handed from the control to the datapath
  typedef struct packed {
    logic access;   // an access takes place on this edge
    logic isWrite;  // the access is a write (else a read)
  } ctl_t;

endpackage

// File: rtl/burst_order.sv
module burst_order #(
  parameter int BITS = 2
) (
  input  logic [BITS-1:0] startLow,
  input  logic [BITS-1:0] count,
  input  logic            interleave,
  output logic [BITS-1:0] seqLow
);

  logic [BITS-1:0] linLow;
  logic [BITS-1:0] xorLow;

  // linear: add modulo 2**BITS, the carry out of the group is dropped
  assign linLow = startLow + count;

  generate
    for (genvar b = 0; b < BITS; b++) begin : gXor
      assign xorLow[b] = startLow[b] ^ count[b];
    end
  endgenerate

  assign seqLow = interleave ? xorLow : linLow;

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipEnN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              allWrN,
  input  logic              sleep,
  input  logic              interleave,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  accLanes
);

  localparam int HI_W = ADDR_W - BURST_BITS;

  // sampled inputs, stored active high
  logic              ceQ, pStbQ, cStbQ, advQ, allWrQ, sleepQ, interQ;
  logic [LANES-1:0]  laneWrQ;
  logic [ADDR_W-1:0] addrQ;

  // burst state
  logic                  burstOn, nxtOn;
  logic [HI_W-1:0]       hiQ, nxtHi;
  logic [BURST_BITS-1:0] startLowQ, nxtStart;
  logic [BURST_BITS-1:0] cntQ, nxtCnt, stepCnt, seqLow;

  logic wrReq, startAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ     <= 1'b0;
      pStbQ   <= 1'b0;
      cStbQ   <= 1'b0;
      advQ    <= 1'b0;
      allWrQ  <= 1'b0;
      sleepQ  <= 1'b0;
      interQ  <= 1'b0;
      laneWrQ <= '0;
      addrQ   <= '0;
    end else begin
      ceQ     <= ~chipEnN;
      pStbQ   <= ~procStrobeN;
      cStbQ   <= ~ctrlStrobeN;
      advQ    <= ~advanceN;
      allWrQ  <= ~allWrN;
      sleepQ  <= sleep;
      interQ  <= interleave;
      laneWrQ <= ~laneWrN;
      addrQ   <= addrIn;
    end
  end

  assign wrReq    = allWrQ | (|laneWrQ);
  assign accLanes = allWrQ ? {LANES{1'b1}} : laneWrQ;
  assign stepCnt  = cntQ + BURST_BITS'(advQ);
  assign startAny = !sleepQ && ceQ && (cStbQ || pStbQ);

  burst_order #(.BITS(BURST_BITS)) uOrder (
    .startLow  (startLowQ),
    .count     (stepCnt),
    .interleave(interQ),
    .seqLow    (seqLow)
  );

  always_comb begin
    ctl      = '0;
    accAddr  = addrQ;
    nxtOn    = burstOn;
    nxtHi    = hiQ;
    nxtStart = startLowQ;
    nxtCnt   = cntQ;
    if (!sleepQ) begin
      if (cStbQ && ceQ) begin
        nxtOn       = 1'b1;
        nxtHi       = addrQ[ADDR_W-1:BURST_BITS];
        nxtStart    = addrQ[BURST_BITS-1:0];
        nxtCnt      = '0;
        ctl.access  = 1'b1;
        ctl.isWrite = wrReq;
      end else if (cStbQ) begin
        nxtOn = 1'b0;
      end else if (pStbQ && ceQ) begin
        nxtOn       = 1'b1;
        nxtHi       = addrQ[ADDR_W-1:BURST_BITS];
        nxtStart    = addrQ[BURST_BITS-1:0];
        nxtCnt      = '0;
        ctl.access  = 1'b1;
        ctl.isWrite = 1'b0;
      end else if (burstOn) begin
        nxtCnt      = stepCnt;
        ctl.access  = 1'b1;
        ctl.isWrite = wrReq;
        accAddr     = {hiQ, seqLow};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn   <= 1'b0;
      hiQ       <= '0;
      startLowQ <= '0;
      cntQ      <= '0;
    end else begin
      burstOn   <= nxtOn;
      hiQ       <= nxtHi;
      startLowQ <= nxtStart;
      cntQ      <= nxtCnt;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (burstOn && !sleepQ && !cStbQ && !(pStbQ && ceQ) && !advQ)
      |=> (burstOn && cntQ == $past(cntQ))); // R8

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    sleepQ |=> ($stable(cntQ) && $stable(burstOn) && $stable(hiQ))); // R12

  AST_DESELECT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (cStbQ && !ceQ && !sleepQ) |=> !burstOn); // R3

  AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.access && !startAny && $past(ctl.access))
      |-> (accAddr[ADDR_W-1:BURST_BITS] == $past(accAddr[ADDR_W-1:BURST_BITS]))); // R6

  AST_PROC_FIRST_READ: assert property (@(posedge clk) disable iff (!rstN)
    (pStbQ && ceQ && !cStbQ && !sleepQ) |-> (ctl.access && !ctl.isWrite)); // R5

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  ctl_t                    ctl,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [LANES-1:0]        accLanes,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dataOut
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataQ <= '0;
    else       dataQ <= dataIn;
  end

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : gLane
      logic [LANE_W-1:0] laneMem [DEPTH];
      logic [LANE_W-1:0] rdLane;

      always_ff @(posedge clk) begin
        if (ctl.access && ctl.isWrite && accLanes[ln])
          laneMem[accAddr] <= dataQ[ln*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          rdLane <= '0;
        else if (ctl.access && !ctl.isWrite) rdLane <= laneMem[accAddr];
        else                                rdLane <= '0;
      end

      assign rdQ[ln*LANE_W +: LANE_W] = rdLane;
    end
  endgenerate

  assign dataOut = outEnN ? '0 : rdQ;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.access && !ctl.isWrite) |=> (rdQ == '0)); // R13

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    chipEnN,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advanceN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    allWrN,
  input  logic                    sleep,
  input  logic                    interleave,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dataOut
);

  ctl_t              ctl;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  accLanes;

  burst_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BURST_BITS(BURST_BITS)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrIn     (addrIn),
    .chipEnN    (chipEnN),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .advanceN   (advanceN),
    .laneWrN    (laneWrN),
    .allWrN     (allWrN),
    .sleep      (sleep),
    .interleave (interleave),
    .ctl        (ctl),
    .accAddr    (accAddr),
    .accLanes   (accLanes)
  );

  sram_datapath #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .ctl     (ctl),
    .accAddr (accAddr),
    .accLanes(accLanes),
    .outEnN  (outEnN),
    .dataOut (dataOut)
  );

endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] dataIn = '0;
  logic          chipEnN = 1'b1, procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic [NL-1:0] laneWrN = '1;
  logic          allWrN = 1'b1, sleep = 1'b0, interleave = 1'b0, outEnN = 1'b0;
  logic [DW-1:0] dataOut;

  always #5 clk = ~clk;

  burst_sram dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .chipEnN(chipEnN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .laneWrN(laneWrN), .allWrN(allWrN), .sleep(sleep),
    .interleave(interleave), .outEnN(outEnN), .dataOut(dataOut)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0]   refMem [0:(1<<AW)-1];
  bit              mOn = 0;
  logic [AW-3:0]   mHi = '0;
  logic [1:0]      mStart = '0, mCnt = '0;

  // expected-value pipeline (two beats deep)
  bit            p0v = 0, p1v = 0;
  logic [DW-1:0] p0e = '0, p1e = '0;
  string         p0t = "", p1t = "";
  bit            oeProbe = 0;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dataOut=%h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] lowBits(logic [1:0] s, logic [1:0] k, bit md);
    return md ? (s ^ k) : 2'(s + k);
  endfunction

  // One beat: check the beat from two cycles ago, model this beat, drive it.
  task automatic beat(bit ce, bit p, bit c, bit adv, logic [NL-1:0] ln, bit gw,
                      logic [AW-1:0] a, bit slp, bit md, string tag);
    logic [DW-1:0] d, e;
    logic [AW-1:0] ad;
    string t;
    bit wr, acc;
    if (oeProbe) begin
      outEnN = 1'b1; #1;
      check("R11", dataOut, '0);
      outEnN = 1'b0; #1;
    end
    if (p1v) check(p1t, dataOut, p1e);
    p1v = p0v; p1e = p0e; p1t = p0t;

    d = DW'({$urandom(), $urandom()});
    wr = gw || (ln != 0);
    e = '0; acc = 0; ad = a; t = "R1";
    if (slp) t = "R12";
    else if (c && ce) begin
      mOn = 1; mHi = a[AW-1:2]; mStart = a[1:0]; mCnt = 0; acc = 1; t = "R3";
    end else if (c) begin
      mOn = 0; t = "R3";
    end else if (p && ce) begin
      mOn = 1; mHi = a[AW-1:2]; mStart = a[1:0]; mCnt = 0; acc = 1;
      t = wr ? "R5" : "R4"; wr = 0;
    end else if (mOn) begin
      if (adv) mCnt = mCnt + 2'd1;
      ad = {mHi, lowBits(mStart, mCnt, md)};
      acc = 1;
      t = adv ? (md ? "R7" : "R6") : "R8";
    end
    if (acc) begin
      if (wr) begin
        for (int i = 0; i < NL; i++)
          if (gw || ln[i]) refMem[ad][i*LW +: LW] = d[i*LW +: LW];
        t = "R13";
      end else begin
        e = refMem[ad];
      end
    end
    if (tag != "") t = tag;
    p0v = 1; p0e = e; p0t = t;

    chipEnN = ~ce; procStrobeN = ~p; ctrlStrobeN = ~c; advanceN = ~adv;
    laneWrN = ~ln; allWrN = ~gw; addrIn = a; sleep = slp; interleave = md;
    dataIn = d;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < (1 << AW); i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", dataOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", dataOut, '0);

    // R1: advance-only cycles with no burst open
    for (int i = 0; i < 3; i++) beat(1, 0, 0, 1, 0, 0, 6'd5, 0, 0, "R1");

    // Fill memory: controller-strobe global write then three linear advance writes
    for (int g = 0; g < 16; g++) begin
      beat(1, 0, 1, 0, 0, 1, 6'(g * 4), 0, 0, "R13");
      for (int k = 0; k < 3; k++) beat(1, 0, 0, 1, 4'hF, 0, 6'd0, 0, 0, "R13");
    end

    // R6 / R7 / R8: every start offset in both orders, with one stall
    for (int md = 0; md < 2; md++)
      for (int off = 0; off < 4; off++) begin
        beat(1, 0, 1, 0, 0, 0, 6'(8 + off), 0, bit'(md), "R2");
        beat(1, 0, 0, 1, 0, 0, 6'd0, 0, bit'(md), md ? "R7" : "R6");
        beat(1, 0, 0, 0, 0, 0, 6'd0, 0, bit'(md), "R8");
        beat(1, 0, 0, 1, 0, 0, 6'd0, 0, bit'(md), md ? "R7" : "R6");
        beat(1, 0, 0, 1, 0, 0, 6'd0, 0, bit'(md), md ? "R7" : "R6");
      end

    // R5: processor strobe with write enables reads on the first beat
    beat(1, 1, 0, 0, 4'hF, 1, 6'd20, 0, 0, "R5");
    beat(1, 0, 0, 1, 0, 0, 6'd0, 0, 0, "R6");

    // R4: processor strobe ignored with chip enable deasserted
    beat(0, 0, 1, 0, 0, 0, 6'd0, 0, 0, "R3");
    beat(0, 1, 0, 0, 0, 0, 6'd24, 0, 0, "R4");
    beat(1, 0, 0, 1, 0, 0, 6'd0, 0, 0, "R4");

    // R4: both strobes, controller wins so the write happens
    beat(1, 1, 1, 0, 4'hF, 0, 6'd28, 0, 0, "R4");
    beat(1, 0, 1, 0, 0, 0, 6'd28, 0, 0, "R4");

    // R9: partial lane write, read back
    beat(1, 0, 1, 0, 4'b0101, 0, 6'd32, 0, 0, "R9");
    beat(1, 0, 1, 0, 0, 0, 6'd32, 0, 0, "R9");
    beat(1, 0, 1, 0, 4'b1000, 0, 6'd33, 0, 0, "R9");
    beat(1, 0, 1, 0, 0, 0, 6'd33, 0, 0, "R9");

    // R10: global write with no lane enables
    beat(1, 0, 1, 0, 0, 1, 6'd36, 0, 0, "R10");
    beat(1, 0, 1, 0, 0, 0, 6'd36, 0, 0, "R10");

    // R12: sleep blocks a write and freezes the burst position
    beat(1, 0, 1, 0, 4'hF, 1, 6'd40, 1, 0, "R12");
    beat(1, 0, 1, 0, 0, 0, 6'd40, 0, 0, "R12");
    beat(1, 0, 1, 0, 0, 0, 6'd44, 0, 0, "R12");
    beat(1, 0, 0, 1, 0, 0, 6'd0, 1, 0, "R12");
    beat(1, 0, 0, 1, 0, 0, 6'd0, 0, 0, "R12");

    // R3: deselect closes the burst
    beat(1, 0, 1, 0, 0, 0, 6'd48, 0, 0, "R3");
    beat(0, 0, 1, 0, 0, 0, 6'd48, 0, 0, "R3");
    beat(1, 0, 0, 1, 0, 0, 6'd0, 0, 0, "R3");

    // R11: output enable probe during a read burst
    beat(1, 0, 1, 0, 0, 0, 6'd52, 0, 1, "R2");
    beat(1, 0, 0, 1, 0, 0, 6'd0, 0, 1, "R7");
    oeProbe = 1;
    beat(1, 0, 0, 1, 0, 0, 6'd0, 0, 1, "R7");
    oeProbe = 0;
    beat(1, 0, 0, 1, 0, 0, 6'd0, 0, 1, "R7");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [NL-1:0] ln;
      r  = int'($urandom % 16);
      ln = ($urandom % 3 == 0) ? NL'($urandom) : '0;
      beat(($urandom % 8) != 0, (r >= 3 && r <= 5), (r < 3), ($urandom % 4) != 0,
           ln, ($urandom % 8) == 0, AW'($urandom), ($urandom % 20) == 0,
           bit'($urandom % 2), "");
    end

    // flush the pipeline with deselect cycles
    for (int i = 0; i < 3; i++) beat(0, 0, 1, 0, 0, 0, 6'd0, 0, 0, "R13");

    done = 1;
    summary();
    $finish;
  end

endmodule